// File: doc/BRIEF.md
# Write Acknowledge Selector

This block picks the acknowledge code for each incoming write request on a serial-bus link. The link side presents one request per strobe. Each request carries a 48-bit destination offset, a flag for a block write with a non-zero extended transaction code, a flag saying the physical request path will serve it, the software posting enable, the posted-slot-full status from the posted-write tracker, and the busy status of the receive queue. The block answers with a complete, pending or busy code. It also gives a post/no-post flag that tells the tracker to reserve a slot.

The decision uses a fixed order of precedence:

1. A busy queue wins over everything else.
2. Extended-code block writes and offsets in the top window are held pending.
3. Physical-path writes are posted only when posting is enabled and a slot is free.
4. Writes in the middle asynchronous window are posted unless the slots are full, in which case they are busied.
5. Every other write is held pending.

The verdict is registered. It appears one clock after the request strobe, together with a one-cycle valid.

A two-state machine sequences the output:

- `ST_IDLE` drives no verdict.
- `ST_ISSUE` presents the verdict latched on the previous edge.
- `IDLE->ISSUE` happens on a request strobe.
- `ISSUE->ISSUE` happens when another strobe arrives back to back.
- `ISSUE->IDLE` happens when no strobe arrives.

Top module: `wack_select`

## Requirements
- R1: While reset is held and on the first cycle after it, `ack_valid` is 0, `ack_code` is 0 and `ack_post` is 0.
- R2: `ack_valid` is 1 in exactly the cycle after each cycle in which `req_valid` is 1, and 0 otherwise. Back-to-back strobes give back-to-back verdicts.
- R3: A request that arrives while `queue_busy` is 1 gets code busy (4h) with `ack_post` 0, whatever its other inputs are.
- R4: A request with `req_ext_tcode` set that is not busied gets code pending (2h) with `ack_post` 0.
- R5: A request that is not busied, with offset from FFFF_0000_0000h to FFFF_FFFF_FFFFh inclusive, gets pending (2h) with `ack_post` 0. This holds even when it is a physical request.
- R6: A request that is not busied, not physical and has no extended code, with offset from 0000_FFFF_FFFFh to FFFE_FFFF_FFFFh inclusive, gets complete (1h) with `ack_post` 1 when `post_full` is 0.
- R7: The same asynchronous-window request gets busy (4h) with `ack_post` 0 when `post_full` is 1.
- R8: A physical request outside the top window, with no extended code and not busied, gets complete (1h) with `ack_post` 1 when `post_enable` is 1 and `post_full` is 0.
- R9: Such a physical request gets pending (2h) with `ack_post` 0 when `post_enable` is 0.
- R10: Such a physical request gets pending (2h) with `ack_post` 0 when `post_enable` is 1 and `post_full` is 1.
- R11: A non-physical request below 0000_FFFF_FFFFh, without an extended code and not busied, gets pending (2h) with `ack_post` 0.
- R12: `ack_post` is 1 only in a cycle where `ack_valid` is 1 and `ack_code` is complete (1h).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request strobe, one cycle per request |
| req_offset | input | 48 | Destination offset of the write |
| req_ext_tcode | input | 1 | Block write with a non-zero extended transaction code |
| req_phys | input | 1 | Request is served by the physical request path |
| post_enable | input | 1 | Software allows posting of physical writes |
| post_full | input | 1 | All posted-write slots are in use |
| queue_busy | input | 1 | Destination receive queue has no space |
| ack_valid | output | 1 | Verdict valid, one cycle after the strobe |
| ack_code | output | 4 | Acknowledge code: 1h complete, 2h pending, 4h busy, 0 when idle |
| ack_post | output | 1 | Reserve a posted-write slot for this request |

## Verification
The assertions take for granted that every qualifying input is stable and meaningful in the cycle `req_valid` is high. They also assume that `post_full` reflects the tracker state seen by this request, not by one the block has just posted. The stimulus drives all request fields together on the falling edge, in the same cycle as the strobe. It changes them only on the next falling edge, so each verdict depends on one coherent set of inputs. The vector table walks every precedence level and both edges of each offset window. Directed tests cover reset, gaps between requests and back-to-back strobes.

// File: rtl/wack_pkg.sv
`timescale 1ns/1ps
package wack_pkg;
    localparam int ACK_W = 4;

    typedef enum logic [ACK_W-1:0] {
        ACK_NONE     = 4'h0,
        ACK_COMPLETE = 4'h1,
        ACK_PENDING  = 4'h2,
        ACK_BUSY     = 4'h4
    } ack_e;

    typedef enum logic [1:0] {
        WIN_LOW  = 2'd0,
        WIN_POST = 2'd1,
        WIN_GAP  = 2'd2,
        WIN_HIGH = 2'd3
    } win_e;

    typedef struct packed {
        ack_e code;
        logic post;
    } verdict_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } st_e;
endpackage

// File: rtl/wack_window.sv
`timescale 1ns/1ps
module wack_window
    import wack_pkg::*;
#(
    parameter int              OFS_W   = 48,
    parameter logic [OFS_W-1:0] POST_LO = 48'h0000_FFFF_FFFF,
    parameter logic [OFS_W-1:0] POST_HI = 48'hFFFE_FFFF_FFFF,
    parameter logic [OFS_W-1:0] HIGH_LO = 48'hFFFF_0000_0000
) (
    input  logic [OFS_W-1:0] offset,
    output win_e             window
);
    always_comb begin
        if (offset >= HIGH_LO)
            window = WIN_HIGH;
        else if (offset > POST_HI)
            window = WIN_GAP;
        else if (offset >= POST_LO)
            window = WIN_POST;
        else
            window = WIN_LOW;
    end
endmodule

// File: rtl/wack_rules.sv
`timescale 1ns/1ps
module wack_rules
    import wack_pkg::*;
(
    input  win_e     window,
    input  logic     ext_tcode,
    input  logic     phys,
    input  logic     post_en,
    input  logic     slots_full,
    input  logic     q_busy,
    output verdict_t verdict
);
    always_comb begin
        verdict = '{code: ACK_PENDING, post: 1'b0};
        if (q_busy) begin
            verdict.code = ACK_BUSY;
        end else if (ext_tcode || window == WIN_HIGH) begin
            verdict.code = ACK_PENDING;
        end else if (phys) begin
            if (post_en && !slots_full) begin
                verdict.code = ACK_COMPLETE;
                verdict.post = 1'b1;
            end
        end else if (window == WIN_POST) begin
            if (slots_full) begin
                verdict.code = ACK_BUSY;
            end else begin
                verdict.code = ACK_COMPLETE;
                verdict.post = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wack_select.sv
`timescale 1ns/1ps
module wack_select
    import wack_pkg::*;
#(
    parameter int OFS_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [OFS_W-1:0] req_offset,
    input  logic             req_ext_tcode,
    input  logic             req_phys,
    input  logic             post_enable,
    input  logic             post_full,
    input  logic             queue_busy,
    output logic             ack_valid,
    output logic [ACK_W-1:0] ack_code,
    output logic             ack_post
);
    localparam logic [OFS_W-1:0] HIGH_LO = {16'hFFFF, {(OFS_W-16){1'b0}}};

    win_e     win;
    verdict_t next_v, held_v;
    st_e      state, state_nx;

    wack_window #(.OFS_W(OFS_W)) u_window (
        .offset (req_offset),
        .window (win)
    );

    wack_rules u_rules (
        .window     (win),
        .ext_tcode  (req_ext_tcode),
        .phys       (req_phys),
        .post_en    (post_enable),
        .slots_full (post_full),
        .q_busy     (queue_busy),
        .verdict    (next_v)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = req_valid ? ST_ISSUE : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            held_v <= '{code: ACK_NONE, post: 1'b0};
        else if (req_valid)
            held_v <= next_v;
        else
            held_v <= '{code: ACK_NONE, post: 1'b0};
    end

    always_comb begin
        ack_valid = 1'b0;
        ack_code  = ACK_NONE;
        ack_post  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ISSUE: begin
                ack_valid = 1'b1;
                ack_code  = held_v.code;
                ack_post  = held_v.post;
            end
            default: ;
        endcase
    end

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ack_valid);
    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ack_valid);
    // R3
    busy_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && queue_busy) |=> (ack_code == 4'h4 && !ack_post));
    // R4
    ext_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !queue_busy && req_ext_tcode) |=> (ack_code == 4'h2));
    // R5
    high_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !queue_busy && req_offset >= HIGH_LO) |=> (ack_code == 4'h2));
    // R7
    full_never_posts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && post_full) |=> !ack_post);
    // R12
    post_means_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_post |-> (ack_valid && ack_code == 4'h1));
endmodule

// File: tb/test_wack_select.sv
`timescale 1ns/1ps
module test_wack_select;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [47:0] req_offset;
    logic        req_ext_tcode, req_phys, post_enable, post_full, queue_busy;
    logic        ack_valid;
    logic [3:0]  ack_code;
    logic        ack_post;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wack_select i_wack_select (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_ext_tcode(req_ext_tcode), .req_phys(req_phys), .post_enable(post_enable),
        .post_full(post_full), .queue_busy(queue_busy),
        .ack_valid(ack_valid), .ack_code(ack_code), .ack_post(ack_post)
    );

    // vector: {busy, ext, phys, pen, full, offset[47:0], code[3:0], post}
    localparam int NV = 15;
    localparam logic [57:0] VEC [NV] = '{
        {5'b11000, 48'hFFFF_0000_0000, 4'h4, 1'b0}, // R3 busy over high window
        {5'b10110, 48'h0000_0000_1000, 4'h4, 1'b0}, // R3 busy over physical post
        {5'b01000, 48'h0001_0000_0000, 4'h2, 1'b0}, // R4 ext code in async window
        {5'b00000, 48'hFFFF_0000_0000, 4'h2, 1'b0}, // R5 high window low edge
        {5'b00110, 48'hFFFF_FFFF_FFFF, 4'h2, 1'b0}, // R5 high window top, physical
        {5'b00000, 48'h0000_FFFF_FFFF, 4'h1, 1'b1}, // R6 async low edge
        {5'b00000, 48'hFFFE_FFFF_FFFF, 4'h1, 1'b1}, // R6 async top edge
        {5'b00001, 48'h1234_5678_9ABC, 4'h4, 1'b0}, // R7 async, slots full
        {5'b00110, 48'h0000_0000_1000, 4'h1, 1'b1}, // R8 physical posted
        {5'b00100, 48'h0000_0000_1000, 4'h2, 1'b0}, // R9 physical, posting off
        {5'b00100, 48'h0001_0000_0000, 4'h2, 1'b0}, // R9 physical in async window
        {5'b00111, 48'h0000_0000_2000, 4'h2, 1'b0}, // R10 physical, slots full
        {5'b00000, 48'h0000_FFFF_FFFE, 4'h2, 1'b0}, // R11 just below async window
        {5'b00000, 48'h0000_0000_0000, 4'h2, 1'b0}, // R11 offset zero
        {5'b00010, 48'h0000_0000_0040, 4'h2, 1'b0}  // R11 non-physical, posting on
    };

    function automatic string req_of(logic [57:0] v);
        if (v[57]) return "R3";
        if (v[56]) return "R4";
        if (v[52:5] >= 48'hFFFF_0000_0000) return "R5";
        if (v[55]) return !v[54] ? "R9" : (v[53] ? "R10" : "R8");
        if (v[52:5] >= 48'h0000_FFFF_FFFF) return v[53] ? "R7" : "R6";
        return "R11";
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,code,post} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(logic [57:0] v);
        req_valid     = 1'b1;
        queue_busy    = v[57];
        req_ext_tcode = v[56];
        req_phys      = v[55];
        post_enable   = v[54];
        post_full     = v[53];
        req_offset    = v[52:5];
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; queue_busy = 1'b0; req_ext_tcode = 1'b0;
        req_phys = 1'b0; post_enable = 1'b0; post_full = 1'b0; req_offset = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        // R1: reset state, with a strobe present during reset
        repeat (2) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        check("R1", {ack_valid, ack_code, ack_post}, 6'b0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {ack_valid, ack_code, ack_post}, 6'b0);

        // vector table, one request then one idle cycle each
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(req_of(VEC[i]), {ack_valid, ack_code, ack_post}, {1'b1, VEC[i][4:0]});
            // R12: post only with complete
            check("R12", {5'b0, ack_post && ack_code != 4'h1}, 6'b0);
            idle_inputs();
            @(negedge clk);
            check("R2", {ack_valid, ack_code, ack_post}, 6'b0);
        end

        // R2: back-to-back strobes, each verdict in the following cycle
        drive({5'b00000, 48'h0000_FFFF_FFFF, 5'b0});
        @(negedge clk);
        check("R2", {ack_valid, ack_code, ack_post}, {1'b1, 4'h1, 1'b1});
        drive({5'b10000, 48'h0000_FFFF_FFFF, 5'b0});
        @(negedge clk);
        check("R3", {ack_valid, ack_code, ack_post}, {1'b1, 4'h4, 1'b0});
        drive({5'b00001, 48'h0000_FFFF_FFFF, 5'b0});
        @(negedge clk);
        check("R7", {ack_valid, ack_code, ack_post}, {1'b1, 4'h4, 1'b0});
        idle_inputs();
        @(negedge clk);
        check("R2", {ack_valid, ack_code, ack_post}, 6'b0);

        // R1: reset in the middle of a verdict clears it
        drive({5'b00110, 48'h0000_0000_1000, 5'b0});
        @(negedge clk);
        check("R8", {ack_valid, ack_code, ack_post}, {1'b1, 4'h1, 1'b1});
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {ack_valid, ack_code, ack_post}, 6'b0);
        idle_inputs();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {ack_valid, ack_code, ack_post}, 6'b0);

        finish_run();
    end
endmodule